// File: doc/BRIEF.md
# Branch History Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small table of per-branch state machines. The table is indexed by a few low bits of the branch's word-aligned address. Fetch presents an address on the lookup port and gets a combinational taken / not-taken guess. When the branch later resolves, the pipeline sends back the address and the real outcome on the update port, and the matching entry is trained.

A parameter picks the width of each entry's state machine:

- **One bit:** the entry remembers the last outcome.
- **Two bits:** the entry is a saturating four-state counter that needs two wrong outcomes in a row to change its guess.

A saturating counter of wrong guesses lets a trace such as a nested loop be scored against the expected miss total. There are no tags, no global history and no target addresses: branches that share an index share an entry.

Top module: `bht_dir_pred`

## Requirements
- R1: After synchronous active-high reset, every entry predicts not taken and the miss counter reads zero.
- R2: With CTR_BITS=1, the lookup prediction for an entry is the outcome of the last update that wrote that entry.
- R3: With CTR_BITS=1, an update whose outcome matches the stored bit leaves the entry unchanged, and an update that disagrees flips the bit.
- R4: With CTR_BITS=2, entries use the encoding 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. States 00 and 01 predict not taken, and states 10 and 11 predict taken.
- R5: With CTR_BITS=2, a taken update steps the entry one state toward 11 and stays at 11. A not-taken update steps it one state toward 00 and stays at 00.
- R6: The entry is selected by address bits [5:2] (IDX_LO=2, IDX_W=4, 16 entries). Addresses that differ only outside those bits share an entry, and training one entry leaves the others unchanged.
- R7: On the clock edge of each valid update whose outcome differs from that entry's pre-update prediction, the miss counter rises by exactly one. Updates that agree with the prediction leave it unchanged.
- R8: A lookup in the same cycle as an update to the same entry returns the pre-update prediction. The new state is visible from the next cycle on.
- R9: While upd_valid is low, upd_pc and upd_taken have no effect on any entry or on the miss counter.
- R10: The miss counter stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | ADDR_W | Address of the branch being looked up |
| lk_pred | output | 1 | Predicted direction for lk_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |
| miss_count | output | MISS_W | Saturating count of mispredicted updates |

## Verification
The checker watches the miss counter on every cycle:
- it clears after reset;
- it moves by at most one per cycle;
- it rises exactly when a valid update disagrees with the entry's current guess;
- it holds when idle or when the guess was right;
- it stays at its ceiling once there.

On every cycle the checker also confirms that a same-entry lookup during an update returns the same pre-update guess that the update port sees.

Only the bench scenarios can show the following:
- the per-mode state sequences, including saturation at both ends of the four-state counter;
- that aliasing follows address bits [5:2];
- that a nested-loop trace yields 1002 misses with one-bit entries and 505 with two-bit entries.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // Two-bit saturating direction states; the upper half predicts taken.
    typedef enum logic [1:0] {
        SAT_STRONG_NT = 2'b00,
        SAT_WEAK_NT   = 2'b01,
        SAT_WEAK_T    = 2'b10,
        SAT_STRONG_T  = 2'b11
    } sat2_e;

    localparam int SAT2_W = 2;

    // Direction guess of a two-bit state.
    function automatic logic sat2_pred(input sat2_e s);
        return (s == SAT_WEAK_T) || (s == SAT_STRONG_T);
    endfunction

    // One training step of a two-bit state, clamped at both ends.
    function automatic sat2_e sat2_next(input sat2_e s, input logic taken);
        sat2_e n;
        case (s)
            SAT_STRONG_NT: n = taken ? SAT_WEAK_NT  : SAT_STRONG_NT;
            SAT_WEAK_NT:   n = taken ? SAT_WEAK_T   : SAT_STRONG_NT;
            SAT_WEAK_T:    n = taken ? SAT_STRONG_T : SAT_WEAK_NT;
            default:       n = taken ? SAT_STRONG_T : SAT_WEAK_T;
        endcase
        return n;
    endfunction

    // Pairing of a guess and the resolved direction of one update.
    typedef struct packed {
        logic pred;
        logic taken;
    } dir_pair_t;

    function automatic logic is_miss(input dir_pair_t p);
        return p.pred != p.taken;
    endfunction

endpackage

// File: rtl/bht_state_decode.sv
module bht_state_decode #(
    parameter int SW = 2
) (
    input  logic [SW-1:0] st,
    output logic          pred
);
    import bht_pkg::*;

    generate
        if (SW == 1) begin : g_one
            assign pred = st[0];
        end else begin : g_two
            assign pred = sat2_pred(sat2_e'(st[1:0]));
        end
    endgenerate
endmodule

// File: rtl/bht_state_next.sv
module bht_state_next #(
    parameter int SW = 2
) (
    input  logic [SW-1:0] cur,
    input  logic          taken,
    output logic [SW-1:0] nxt
);
    import bht_pkg::*;

    generate
        if (SW == 1) begin : g_one
            // Keep the bit on a correct guess, invert it on a wrong one.
            assign nxt = (cur[0] == taken) ? cur : ~cur;
        end else begin : g_two
            assign nxt = SW'(sat2_next(sat2_e'(cur[1:0]), taken));
        end
    endgenerate
endmodule

// File: rtl/bht_table.sv
module bht_table #(
    parameter int IDX_W = 4,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [SW-1:0]    rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [SW-1:0]    rd_b_st,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SW-1:0]    wr_st
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][SW-1:0] ent;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            logic [SW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    q <= wr_st;
                end
            end
            assign ent[g] = q;
        end
    endgenerate

    // Reads return registered state, so a same-cycle write is not yet seen.
    assign rd_a_st = ent[rd_a_idx];
    assign rd_b_st = ent[rd_b_idx];
endmodule

// File: rtl/bht_miss_ctr.sv
module bht_miss_ctr #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [MISS_W-1:0] count
);
    localparam logic [MISS_W-1:0] TOP = '1;

    logic [MISS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + MISS_W'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/bht_dir_pred.sv
module bht_dir_pred #(
    parameter int ADDR_W   = 32,
    parameter int IDX_LO   = 2,
    parameter int IDX_W    = 4,
    parameter int CTR_BITS = 2,
    parameter int MISS_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_pred,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    output logic [MISS_W-1:0] miss_count
);
    import bht_pkg::*;

    localparam int SW = (CTR_BITS == 1) ? 1 : SAT2_W;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [SW-1:0]    lk_st;
    logic [SW-1:0]    upd_st;
    logic [SW-1:0]    upd_nxt;
    logic             upd_pred_w;
    logic             miss_w;
    dir_pair_t        upd_pair;

    assign lk_idx  = lk_pc[IDX_LO +: IDX_W];
    assign upd_idx = upd_pc[IDX_LO +: IDX_W];

    // Address bits outside the index field carry no meaning here.
    logic unused_addr_bits;
    assign unused_addr_bits = ^{lk_pc, upd_pc};

    bht_table #(.IDX_W(IDX_W), .SW(SW)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_idx),
        .rd_a_st  (lk_st),
        .rd_b_idx (upd_idx),
        .rd_b_st  (upd_st),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_st    (upd_nxt)
    );

    bht_state_decode #(.SW(SW)) lk_dec_i (
        .st   (lk_st),
        .pred (lk_pred)
    );

    bht_state_decode #(.SW(SW)) upd_dec_i (
        .st   (upd_st),
        .pred (upd_pred_w)
    );

    bht_state_next #(.SW(SW)) nxt_i (
        .cur   (upd_st),
        .taken (upd_taken),
        .nxt   (upd_nxt)
    );

    assign upd_pair = '{pred: upd_pred_w, taken: upd_taken};
    assign miss_w   = upd_valid && is_miss(upd_pair);

    bht_miss_ctr #(.MISS_W(MISS_W)) miss_i (
        .clk   (clk),
        .rst   (rst),
        .inc   (miss_w),
        .count (miss_count)
    );
endmodule

// File: rtl/bht_dir_pred_chk.sv
module bht_dir_pred_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_LO = 2,
    parameter int IDX_W  = 4,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_pred,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic              upd_pred,
    input logic [MISS_W-1:0] miss_count
);
    localparam logic [MISS_W-1:0] TOP = '1;

    logic same_ent;
    assign same_ent = lk_pc[IDX_LO +: IDX_W] == upd_pc[IDX_LO +: IDX_W];

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> miss_count == '0);

    a_r7_step_bound: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (miss_count == $past(miss_count)) ||
                 (miss_count == $past(miss_count) + MISS_W'(1)));

    a_r7_count_miss: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (upd_taken != upd_pred) && (miss_count != TOP))
        |=> miss_count == $past(miss_count) + MISS_W'(1));

    a_r7_hold_on_hit: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (upd_taken == upd_pred)) |=> $stable(miss_count));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(miss_count));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (miss_count == TOP) |=> miss_count == TOP);

    a_r8_pre_update_view: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && same_ent) |-> lk_pred == upd_pred);
endmodule

bind bht_dir_pred bht_dir_pred_chk #(
    .ADDR_W (ADDR_W),
    .IDX_LO (IDX_LO),
    .IDX_W  (IDX_W),
    .MISS_W (MISS_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .lk_pc      (lk_pc),
    .lk_pred    (lk_pred),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_pred   (upd_pred_w),
    .miss_count (miss_count)
);

// File: tb/bht_dir_pred_tb_top.sv
module bht_dir_pred_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int MISS_W     = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] lk_pc = '0;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_pc = '0;
    logic              upd_taken = 1'b0;
    logic              pred2;
    logic              pred1;
    logic [MISS_W-1:0] miss2;
    logic [MISS_W-1:0] miss1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Two-bit entries
    bht_dir_pred #(.ADDR_W(ADDR_W), .CTR_BITS(2), .MISS_W(MISS_W)) dut_i (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(pred2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .miss_count(miss2)
    );

    // One-bit entries, same stimulus
    bht_dir_pred #(.ADDR_W(ADDR_W), .CTR_BITS(1), .MISS_W(MISS_W)) dut_b_i (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(pred1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .miss_count(miss1)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One update cycle; returns just after the edge that applies it.
    task automatic upd(input logic [ADDR_W-1:0] pc, input logic t);
        @(negedge clk);
        upd_pc = pc;
        upd_taken = t;
        upd_valid = 1'b1;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [ADDR_W-1:0] pc);
        lk_pc = pc;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 miss2 after reset", int'(miss2), 0);
        check("R1 miss1 after reset", int'(miss1), 0);
        for (int i = 0; i < 16; i++) begin
            look(ADDR_W'(i * 4));
            check("R1 pred2 after reset", int'(pred2), 0);
            check("R1 pred1 after reset", int'(pred1), 0);
        end
    endtask

    task automatic t_modes();
        // Sequence at 0x20: T T N N
        do_reset();
        look(32'h20);
        upd(32'h20, 1'b1);
        check("R2 pred1 after T", int'(pred1), 1);
        check("R3 miss1 flip", int'(miss1), 1);
        check("R4 pred2 weak-nt", int'(pred2), 0);
        check("R7 miss2 first T", int'(miss2), 1);
        upd(32'h20, 1'b1);
        check("R3 pred1 unchanged on hit", int'(pred1), 1);
        check("R3 miss1 hit", int'(miss1), 1);
        check("R4 pred2 weak-t", int'(pred2), 1);
        check("R7 miss2 second T", int'(miss2), 2);
        upd(32'h20, 1'b0);
        check("R2 pred1 after N", int'(pred1), 0);
        check("R7 miss1 after N", int'(miss1), 2);
        check("R5 pred2 back to weak-nt", int'(pred2), 0);
        check("R7 miss2 after N", int'(miss2), 3);
        upd(32'h20, 1'b0);
        check("R3 pred1 stays N", int'(pred1), 0);
        check("R7 miss2 hit N", int'(miss2), 3);
        // Four taken, then N: upper clamp keeps a taken guess
        for (int k = 0; k < 4; k++) upd(32'h20, 1'b1);
        check("R5 pred2 strong-t", int'(pred2), 1);
        upd(32'h20, 1'b0);
        check("R5 upper clamp", int'(pred2), 1);
        upd(32'h20, 1'b0);
        check("R5 down to weak-nt", int'(pred2), 0);
        // More N, then one T: lower clamp keeps a not-taken guess
        for (int k = 0; k < 3; k++) upd(32'h20, 1'b0);
        upd(32'h20, 1'b1);
        check("R5 lower clamp", int'(pred2), 0);
        check("R2 pred1 last T", int'(pred1), 1);
    endtask

    task automatic t_index();
        do_reset();
        upd(32'h0000_0104, 1'b1);
        upd(32'h0000_0104, 1'b1);
        look(32'h0000_0004);
        check("R6 alias pred1", int'(pred1), 1);
        check("R6 alias pred2", int'(pred2), 1);
        look(32'hFFFF_FFC4);
        check("R6 high alias pred2", int'(pred2), 1);
        look(32'h0000_0008);
        check("R6 neighbour pred1", int'(pred1), 0);
        check("R6 neighbour pred2", int'(pred2), 0);
        look(32'h0000_0044);
        check("R6 bit6 alias pred1", int'(pred1), 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        lk_pc = 32'h10;
        upd_pc = 32'h10;
        upd_taken = 1'b1;
        upd_valid = 1'b1;
        #1;
        check("R8 pred1 pre-update", int'(pred1), 0);
        check("R8 pred2 pre-update", int'(pred2), 0);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        check("R8 pred1 next cycle", int'(pred1), 1);
        check("R8 pred2 next cycle weak-nt", int'(pred2), 0);
    endtask

    task automatic t_idle();
        do_reset();
        @(negedge clk);
        upd_pc = 32'h18;
        upd_taken = 1'b1;
        upd_valid = 1'b0;
        repeat (5) @(negedge clk);
        look(32'h18);
        check("R9 pred1 idle", int'(pred1), 0);
        check("R9 pred2 idle", int'(pred2), 0);
        check("R9 miss1 idle", int'(miss1), 0);
        check("R9 miss2 idle", int'(miss2), 0);
    endtask

    task automatic t_loops();
        // 500 outer passes of a 4-pass inner loop
        do_reset();
        for (int o = 0; o < 500; o++) begin
            for (int j = 0; j < 4; j++) upd(32'h40, j < 3);
            upd(32'h4C, o < 499);
        end
        check("R7 nested trace miss1", int'(miss1), 1002);
        check("R7 nested trace miss2", int'(miss2), 505);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int k = 0; k < 1030; k++) upd(32'h30, (k % 2) == 0);
        check("R10 miss1 clamped", int'(miss1), 1023);
        check("R7 miss2 alternating", int'(miss2), 515);
        upd(32'h30, 1'b1);
        check("R10 miss1 stays clamped", int'(miss1), 1023);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_index();
        t_same_cycle();
        t_idle();
        t_loops();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule